// File: doc/BRIEF.md
# Complementary Output Generator with Dead Band

This block turns one square-wave source into a pair of complementary drive signals for the two halves of an H-bridge. Channel A follows the source and channel B follows its inverse. Whenever the source changes level, both channels are first held inactive for a programmable number of clock cycles, and only then is the newly selected channel switched on. Separate counts set this gap for rising and for falling source edges, so the high-side and low-side switches never conduct together.

A fault input forces the block into a shutdown state. In shutdown each channel is driven to its own programmed level. Shutdown ends either when software clears the flag through the write port, or by itself once the fault input drops, if automatic restart is selected. Each channel also has its own polarity inversion. Software programs everything through a small parallel write port. Software is expected to clear the enable while it changes the dead-band, shutdown or source settings.

Top module: `comp_drive_gen`

## Requirements
- R1: After reset the block is disabled, both outputs are low and the shutdown flag is clear.
- R2: When the block is enabled and running with normal polarity, output A is high while the sampled source is high, and output B is high while the source is low.
- R3: A rising source edge seen at a clock edge holds both outputs low for exactly `rise` cycles (register 1, bits DB_W-1:0), and then raises A. A count of 0 raises A at that same clock edge.
- R4: A falling source edge holds both outputs low for exactly `fall` cycles (register 2), and then raises B. This count is independent of the rising one.
- R5: While enabled, out of shutdown and with both polarity bits clear, A and B are never high in the same cycle.
- R6: If the source changes again before a dead-band count has run out, the count restarts with the count for the new edge, and the channel that was pending is never asserted.
- R7: Control bit 1 inverts output A and control bit 2 inverts output B, each on its own and from the next clock.
- R8: While enabled, a high fault input sets the shutdown flag on the next clock. While the flag is set, A is driven to shutdown register bit 0 and B to bit 1.
- R9: With automatic restart off (control bit 3 = 0), the flag stays set until a write to register 3 with bit 2 = 0. After that, operation resumes with the dead band for the current source level.
- R10: With automatic restart on (control bit 3 = 1), the flag clears on the first clock at which the fault input is low. The resumed output then gets the dead band for the current source level.
- R11: With the enable (control bit 0) clear, both outputs are low and a high fault input does not set the flag.
- R12: The write port selects a register by a 2-bit address: 0 = control, 1 = rising count, 2 = falling count, 3 = shutdown. A write takes effect at the clock edge at which `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the time base for the dead-band counts |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W | Write data |
| src_in | input | 1 | Square-wave source |
| trip_in | input | 1 | Fault input that requests shutdown |
| out_a | output | 1 | Drive channel A (follows source) |
| out_b | output | 1 | Drive channel B (follows inverse source) |
| shut_flag | output | 1 | Shutdown flag |

## Verification
Two pairs of events can land on the same clock edge. A source edge can arrive while a dead-band count is still running. The end of a shutdown, whether from a software clear or an automatic restart, coincides with reloading the dead-band counter. The bench provokes the first case by reversing the source halfway through a rising dead band. It then expects two further low cycles of the falling count followed by B alone, with A never seen high. It provokes the second case by releasing shutdown while the source is low. It expects the outputs to drop from the shutdown levels to both-low for the full falling count before B rises.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_RISE = 2'd1;
    localparam logic [ADDR_W-1:0] REG_FALL = 2'd2;
    localparam logic [ADDR_W-1:0] REG_SHUT = 2'd3;

    typedef struct packed {
        logic auto_rs;
        logic inv_b;
        logic inv_a;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic flag_bit;
        logic lvl_b;
        logic lvl_a;
    } shut_cfg_t;

    typedef enum logic {
        PH_DEAD = 1'b0,
        PH_LIVE = 1'b1
    } phase_t;

    // Count that applies when the source settles at level 'lvl'
    function automatic logic [15:0] gap_for(input logic lvl,
                                            input logic [15:0] rise_n,
                                            input logic [15:0] fall_n);
        return lvl ? rise_n : fall_n;
    endfunction

endpackage

// File: rtl/cdg_regs.sv
module cdg_regs
    import cdg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DB_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trip_in,
    output ctrl_t             ctrl,
    output logic [DB_W-1:0]   rise_n,
    output logic [DB_W-1:0]   fall_n,
    output logic              lvl_a,
    output logic              lvl_b,
    output logic              shut_flag
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int SHUT_W = $bits(shut_cfg_t);

    shut_cfg_t wr_shut;
    ctrl_t     wr_ctrl;

    assign wr_shut = shut_cfg_t'(wr_data[SHUT_W-1:0]);
    assign wr_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            rise_n <= '0;
            fall_n <= '0;
            lvl_a  <= 1'b0;
            lvl_b  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: ctrl   <= wr_ctrl;
                REG_RISE: rise_n <= wr_data[DB_W-1:0];
                REG_FALL: fall_n <= wr_data[DB_W-1:0];
                default: begin
                    lvl_a <= wr_shut.lvl_a;
                    lvl_b <= wr_shut.lvl_b;
                end
            endcase
        end
    end

    // Priority: fault input, then software write, then automatic restart
    always_ff @(posedge clk) begin
        if (rst) begin
            shut_flag <= 1'b0;
        end else if (ctrl.enable && trip_in) begin
            shut_flag <= 1'b1;
        end else if (wr_en && wr_addr == REG_SHUT) begin
            shut_flag <= wr_shut.flag_bit;
        end else if (ctrl.auto_rs && !trip_in) begin
            shut_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cdg_deadband.sv
module cdg_deadband
    import cdg_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            src,
    input  logic [DB_W-1:0] rise_n,
    input  logic [DB_W-1:0] fall_n,
    output logic            raw_a,
    output logic            raw_b
);

    logic            src_q;
    logic            target;
    phase_t          phase;
    logic [DB_W-1:0] cnt;
    logic [DB_W-1:0] load_n;
    logic            do_load;

    assign load_n  = DB_W'(gap_for(src, 16'(rise_n), 16'(fall_n)));
    assign do_load = restart || (src != src_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= 1'b0;
            target <= 1'b0;
            phase  <= PH_DEAD;
            cnt    <= '0;
        end else if (do_load) begin
            src_q  <= src;
            target <= src;
            cnt    <= load_n;
            phase  <= (load_n == '0) ? PH_LIVE : PH_DEAD;
        end else if (phase == PH_DEAD) begin
            if (cnt <= DB_W'(1)) begin
                phase <= PH_LIVE;
                cnt   <= '0;
            end else begin
                cnt <= cnt - DB_W'(1);
            end
        end
    end

    assign raw_a = (phase == PH_LIVE) &&  target;
    assign raw_b = (phase == PH_LIVE) && !target;

endmodule

// File: rtl/cdg_outmux.sv
module cdg_outmux #(
    parameter int N_CH = 2
) (
    input  logic            enable,
    input  logic            shut,
    input  logic [N_CH-1:0] raw,
    input  logic [N_CH-1:0] inv,
    input  logic [N_CH-1:0] lvl,
    output logic [N_CH-1:0] drv
);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        always_comb begin
            if (!enable)   drv[ch] = 1'b0;
            else if (shut) drv[ch] = lvl[ch];
            else           drv[ch] = raw[ch] ^ inv[ch];
        end
    end

endmodule

// File: rtl/comp_drive_gen.sv
module comp_drive_gen
    import cdg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DB_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              src_in,
    input  logic              trip_in,
    output logic              out_a,
    output logic              out_b,
    output logic              shut_flag
);

    ctrl_t           ctrl;
    logic [DB_W-1:0] rise_n;
    logic [DB_W-1:0] fall_n;
    logic            lvl_a;
    logic            lvl_b;
    logic            raw_a;
    logic            raw_b;
    logic [1:0]      drv;

    logic en_s;
    logic auto_s;
    logic inv_a_s;
    logic inv_b_s;

    assign en_s    = ctrl.enable;
    assign auto_s  = ctrl.auto_rs;
    assign inv_a_s = ctrl.inv_a;
    assign inv_b_s = ctrl.inv_b;

    cdg_regs #(.DATA_W(DATA_W), .DB_W(DB_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .trip_in   (trip_in),
        .ctrl      (ctrl),
        .rise_n    (rise_n),
        .fall_n    (fall_n),
        .lvl_a     (lvl_a),
        .lvl_b     (lvl_b),
        .shut_flag (shut_flag)
    );

    cdg_deadband #(.DB_W(DB_W)) u_db (
        .clk     (clk),
        .rst     (rst),
        .restart (!en_s || shut_flag),
        .src     (src_in),
        .rise_n  (rise_n),
        .fall_n  (fall_n),
        .raw_a   (raw_a),
        .raw_b   (raw_b)
    );

    cdg_outmux #(.N_CH(2)) u_mux (
        .enable (en_s),
        .shut   (shut_flag),
        .raw    ({raw_b, raw_a}),
        .inv    ({inv_b_s, inv_a_s}),
        .lvl    ({lvl_b, lvl_a}),
        .drv    (drv)
    );

    assign out_a = drv[0];
    assign out_b = drv[1];

endmodule

// File: rtl/comp_drive_gen_chk.sv
module comp_drive_gen_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic trip_in,
    input logic out_a,
    input logic out_b,
    input logic shut_flag,
    input logic en_s,
    input logic auto_s,
    input logic inv_a_s,
    input logic inv_b_s,
    input logic lvl_a,
    input logic lvl_b
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !out_a && !out_b && !shut_flag); // R1

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        en_s && !shut_flag && !inv_a_s && !inv_b_s |-> !(out_a && out_b)); // R5

    AST_SHUT_LEVELS: assert property (@(posedge clk) disable iff (rst)
        en_s && shut_flag |-> out_a == lvl_a && out_b == lvl_b); // R8

    AST_TRIP_SETS: assert property (@(posedge clk) disable iff (rst)
        en_s && trip_in |=> shut_flag); // R8

    AST_LATCHED_SHUT: assert property (@(posedge clk) disable iff (rst)
        shut_flag && !auto_s && !wr_en |=> shut_flag); // R9

    AST_AUTO_RESUME: assert property (@(posedge clk) disable iff (rst)
        shut_flag && auto_s && !trip_in && !wr_en |=> !shut_flag); // R10

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en_s |-> !out_a && !out_b); // R11

endmodule

bind comp_drive_gen comp_drive_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .trip_in   (trip_in),
    .out_a     (out_a),
    .out_b     (out_b),
    .shut_flag (shut_flag),
    .en_s      (en_s),
    .auto_s    (auto_s),
    .inv_a_s   (inv_a_s),
    .inv_b_s   (inv_b_s),
    .lvl_a     (lvl_a),
    .lvl_b     (lvl_b)
);

// File: tb/comp_drive_gen_test.sv
module comp_drive_gen_test;

    localparam int CLK_P = 10;

    typedef struct {
        logic  a;
        logic  b;
        logic  f;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       src_in = 1'b0;
    logic       trip_in = 1'b0;
    logic       out_a;
    logic       out_b;
    logic       shut_flag;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    comp_drive_gen uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .src_in    (src_in),
        .trip_in   (trip_in),
        .out_a     (out_a),
        .out_b     (out_b),
        .shut_flag (shut_flag)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (out_a !== e.a || out_b !== e.b || shut_flag !== e.f) begin
            errors++;
            $display("FAIL %s: got a=%b b=%b flag=%b expected a=%b b=%b flag=%b",
                     e.tag, out_a, out_b, shut_flag, e.a, e.b, e.f);
        end
    endtask

    // Monitor: pops the item pushed before this edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    task automatic wr(input logic [1:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = data;
    endtask

    task automatic step(input logic s, input logic t,
                        input logic ea, input logic eb, input logic ef,
                        input string tag);
        exp_t e;
        @(negedge clk);
        wr_en   = 1'b0;
        src_in  = s;
        trip_in = t;
        e.a = ea; e.b = eb; e.f = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        begin
            exp_t e0;
            e0.a = 0; e0.b = 0; e0.f = 0; e0.tag = "R1 reset state";
            compare(e0);
        end

        // R12 register map: 1 rise, 2 fall, 3 shutdown, 0 control
        wr(2'd1, 8'd3);
        wr(2'd2, 8'd2);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h01);
        step(0, 0, 0, 0, 0, "R2 enable dead band");
        step(0, 0, 0, 1, 0, "R2 B follows low source");
        step(0, 0, 0, 1, 0, "R2 B held");

        // R3 rising edge, count 3
        step(1, 0, 0, 0, 0, "R3 dead 1");
        step(1, 0, 0, 0, 0, "R3 dead 2");
        step(1, 0, 0, 0, 0, "R3 dead 3");
        step(1, 0, 1, 0, 0, "R3 A asserts");
        step(1, 0, 1, 0, 0, "R2 A follows high source");

        // R4 falling edge, count 2
        step(0, 0, 0, 0, 0, "R4 dead 1");
        step(0, 0, 0, 0, 0, "R4 dead 2");
        step(0, 0, 0, 1, 0, "R4 B asserts");
        step(0, 0, 0, 1, 0, "R4 B held");

        // R6 retrigger inside rising dead band
        step(1, 0, 0, 0, 0, "R6 rise dead");
        step(1, 0, 0, 0, 0, "R6 rise dead");
        step(0, 0, 0, 0, 0, "R6 reversal reloads fall count");
        step(0, 0, 0, 0, 0, "R6 fall dead");
        step(0, 0, 0, 1, 0, "R6 B only, A dropped");
        step(0, 0, 0, 1, 0, "R6 B held");

        // R3 zero count
        wr(2'd1, 8'd0);
        step(1, 0, 1, 0, 0, "R3 zero count immediate A");
        step(1, 0, 1, 0, 0, "R3 zero count A held");
        step(0, 0, 0, 0, 0, "R4 dead after zero rise");
        step(0, 0, 0, 0, 0, "R4 dead 2");
        step(0, 0, 0, 1, 0, "R4 B asserts");

        // R7 polarity
        wr(2'd0, 8'h03);
        step(0, 0, 1, 1, 0, "R7 A inverted");
        wr(2'd0, 8'h05);
        step(0, 0, 0, 0, 0, "R7 B inverted");
        wr(2'd0, 8'h01);
        step(0, 0, 0, 1, 0, "R7 normal polarity");

        // R8/R9 shutdown, A level 1, B level 0, no auto restart
        wr(2'd3, 8'h01);
        step(0, 1, 1, 0, 1, "R8 trip sets flag and levels");
        step(0, 0, 1, 0, 1, "R9 flag held after trip drops");
        step(0, 0, 1, 0, 1, "R9 flag still held");
        wr(2'd3, 8'h01);
        step(0, 0, 0, 0, 0, "R9 cleared, dead band");
        step(0, 0, 0, 1, 0, "R9 resume B");

        // R10 auto restart
        wr(2'd0, 8'h09);
        step(0, 1, 1, 0, 1, "R10 trip sets flag");
        step(0, 1, 1, 0, 1, "R10 held while trip high");
        step(0, 0, 0, 0, 0, "R10 auto clear, dead 1");
        step(0, 0, 0, 0, 0, "R10 dead 2");
        step(0, 0, 0, 1, 0, "R10 resume B");

        // R11 disabled
        wr(2'd0, 8'h00);
        step(0, 1, 0, 0, 0, "R11 trip ignored when disabled");
        step(1, 1, 0, 0, 0, "R11 outputs low, flag clear");
        step(1, 0, 0, 0, 0, "R11 still low");

        wait (sb.size() == 0);
        @(posedge clk);
        #5;
        finish_run();
    end

endmodule